// File: doc/BRIEF.md
# Horizontal Polyphase Bilinear Resampler

This block resizes video one line at a time along the horizontal axis. Pixels of 24 bits (three 8-bit channels) enter through a valid-ready port and the block emits a programmed number of output pixels per line through a second valid-ready port. A 12.12 fixed-point position accumulator starts at zero on each line and steps by a programmable pitch for every output pixel. The pitch is (input width / output width) × 4096; for example, 640 to 1024 gives 2560.

Each output pixel blends two neighbouring input pixels. The integer part of the position picks the left pixel. The next four fractional bits pick one of 16 phases in a programmable weight bank. The blend is done separately on each channel. Line-start and frame-start markers are regenerated on the output side. When upscaling, the block can emit one pixel every clock. It drops input ready in the cycles where it does not need a new pixel, so either port can stall without affecting the other.

Top module: `hscale_resampler`

## Requirements
- R1: Output pixel k of a line (k counted from 0) uses position P = (k × pitch) mod 2^24. The left index is P[23:12], the phase is P[11:8] and the right index is the left index + 1.
- R2: Each 8-bit channel (bits [7:0], [15:8] and [23:16]) of an output equals (left × (256 − w) + right × w + 128) >> 8, where w is the right-tap weight of the selected phase.
- R3: The weight bank holds 16 unsigned 8-bit right-tap weights, and the left weight is always 256 − w. After reset, phase p holds w = 16·p, which gives linear interpolation. A clock edge with coef_we high writes coef_w into entry coef_idx.
- R4: A pixel moves only on a clock edge where its valid and ready are both high. While out_vld is high and out_rdy is low, out_vld stays high and out_pix does not change.
- R5: Input cycles with in_vld low have no effect, whatever values in_pix, in_hs and in_vs carry.
- R6: out_hs is high on the first output pixel of a line and on no other pixel. out_vs is high only on that pixel, and only when the first input pixel of the line had in_vs high.
- R7: When pitch is below 4096 and both sides run at full rate, the output pixels of a line leave on consecutive clocks. The block drops in_rdy while it still holds the input pixels it needs.
- R8: Both tap indices are clamped to in_ppl − 1, so positions at or past the last input pixel reuse that pixel.
- R9: Exactly out_ppl pixels are produced per line. After that, out_vld stays low, and input pixels without in_hs are accepted (in_rdy high) and discarded until a new line starts.
- R10: An accepted pixel with in_hs high starts a new line: the position resets to zero and the pixel becomes input index 0.
- R11: After reset, out_vld is low and in_rdy is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| pitch | input | 24 | Position step per output pixel, unsigned 12.12 |
| in_ppl | input | 16 | Input pixels per line |
| out_ppl | input | 16 | Output pixels per line |
| coef_we | input | 1 | Weight bank write strobe |
| coef_idx | input | 4 | Phase entry to write |
| coef_w | input | 8 | Right-tap weight to write |
| in_pix | input | 24 | Input pixel, three 8-bit channels |
| in_vld | input | 1 | Input pixel valid |
| in_hs | input | 1 | Input line start marker |
| in_vs | input | 1 | Input frame start marker |
| in_rdy | output | 1 | Block accepts an input pixel |
| out_pix | output | 24 | Output pixel |
| out_vld | output | 1 | Output pixel valid |
| out_hs | output | 1 | Output line start marker |
| out_vs | output | 1 | Output frame start marker |
| out_rdy | input | 1 | Downstream accepts an output pixel |

## Verification
A corrupt position accumulator or a bad tap selection shows up as a wrong output value on the very next accepted pixel. The bench computes the expected value of every output pixel, so a single wrong blend is caught at once. A wrong received-pixel or output count shows up within the same line: the line either ends with too few or too many outputs, or in_rdy stalls for good, which the per-line guard reports. Marker state errors are seen on the first output of the next line. Random valid and ready gaps make each handshake error show up as held data that changes, or as an input pixel that is lost or taken twice.

// File: rtl/hscale_pkg.sv
// Shared constants and helpers for the horizontal resampler.
// Assumes weights are right-tap weights; the left weight is the complement to 2^COEF_W.
package hscale_pkg;
    parameter int CH_W_D   = 8;
    parameter int NCH_D    = 3;
    parameter int CNT_W_D  = 16;
    parameter int ACC_W_D  = 24;
    parameter int FRAC_W_D = 12;
    parameter int PH_W_D   = 4;
    parameter int COEF_W_D = 8;

    // Linear-interpolation right weight for phase p.
    function automatic logic [COEF_W_D-1:0] lin_weight(input int p);
        return COEF_W_D'(p << (COEF_W_D - PH_W_D));
    endfunction
endpackage

// File: rtl/hscale_coef_bank.sv
// Weight bank: one right-tap weight per phase, loaded with a linear ramp on reset.
// Assumes a write and a read of the same entry in one cycle returns the old value.
module hscale_coef_bank
    import hscale_pkg::*;
#(
    parameter int PH_W   = PH_W_D,
    parameter int COEF_W = COEF_W_D
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [PH_W-1:0]   wr_idx,
    input  logic [COEF_W-1:0] wr_w,
    input  logic [PH_W-1:0]   rd_idx,
    output logic [COEF_W-1:0] rd_w
);
    localparam int NPH = 1 << PH_W;

    logic [COEF_W-1:0] bank [NPH];

    // Reset to the linear ramp, otherwise apply the write strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int p = 0; p < NPH; p++) bank[p] <= COEF_W'(p << (COEF_W - PH_W));
        end else if (we) begin
            bank[wr_idx] <= wr_w;
        end
    end

    // Asynchronous read of the current phase.
    always_comb rd_w = bank[rd_idx];
endmodule

// File: rtl/hscale_ctrl.sv
// Line controller: tracks received pixels and the output position, keeps a two-pixel
// window, and drives both handshakes. It never takes an input pixel past the one the
// current position needs, so the window always holds the taps of the current output.
// Assumes pitch, in_ppl and out_ppl are stable while a line is in progress.
module hscale_ctrl
    import hscale_pkg::*;
#(
    parameter int PIX_W  = CH_W_D * NCH_D,
    parameter int CNT_W  = CNT_W_D,
    parameter int ACC_W  = ACC_W_D,
    parameter int FRAC_W = FRAC_W_D,
    parameter int PH_W   = PH_W_D
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [ACC_W-1:0] pitch,
    input  logic [CNT_W-1:0] in_ppl,
    input  logic [CNT_W-1:0] out_ppl,
    input  logic [PIX_W-1:0] in_pix,
    input  logic             in_vld,
    input  logic             in_hs,
    input  logic             in_vs,
    output logic             in_rdy,
    input  logic             out_rdy,
    output logic             out_vld,
    output logic             out_hs,
    output logic             out_vs,
    output logic [PIX_W-1:0] tap_l,
    output logic [PIX_W-1:0] tap_r,
    output logic [PH_W-1:0]  phase
);
    localparam int TW = CNT_W + 1;

    logic [ACC_W-1:0] acc, nacc;
    logic [CNT_W-1:0] rcv, ocnt;
    logic [PIX_W-1:0] prev, cur;
    logic             active, vs_line;
    logic [TW-1:0]    lp2, lp2n, tgt, tgt_n, ppl_x, rcv_x;
    logic             last, out_fire, in_fire, clamp;

    // Window targets for the current and the next output position.
    always_comb begin
        nacc  = acc + pitch;
        ppl_x = TW'(in_ppl);
        rcv_x = TW'(rcv);
        lp2   = TW'(acc[ACC_W-1:FRAC_W]) + TW'(2);
        lp2n  = TW'(nacc[ACC_W-1:FRAC_W]) + TW'(2);
        clamp = lp2 > ppl_x;
        tgt   = clamp ? ppl_x : lp2;
        tgt_n = (lp2n > ppl_x) ? ppl_x : lp2n;
    end

    // Handshakes: output when the window is filled, input when more pixels are needed.
    always_comb begin
        last     = (ocnt == out_ppl - CNT_W'(1));
        out_vld  = active && (rcv_x >= tgt);
        out_fire = out_vld && out_rdy;
        in_rdy   = !active || (rcv_x < tgt) || (out_fire && !last && (rcv_x < tgt_n));
        in_fire  = in_vld && in_rdy;
        out_hs   = out_vld && (ocnt == '0);
        out_vs   = out_hs && vs_line;
        tap_r    = cur;
        tap_l    = clamp ? cur : prev;
        phase    = acc[FRAC_W-1 -: PH_W];
    end

    // Line state: restart on a marked pixel, else shift the window and step the position.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc     <= '0;
            rcv     <= '0;
            ocnt    <= '0;
            prev    <= '0;
            cur     <= '0;
            active  <= 1'b0;
            vs_line <= 1'b0;
        end else if (in_fire && in_hs) begin
            cur     <= in_pix;
            rcv     <= CNT_W'(1);
            acc     <= '0;
            ocnt    <= '0;
            active  <= (out_ppl != '0);
            vs_line <= in_vs;
        end else begin
            if (in_fire && active) begin
                prev <= cur;
                cur  <= in_pix;
                rcv  <= rcv + CNT_W'(1);
            end
            if (out_fire) begin
                acc  <= nacc;
                ocnt <= ocnt + CNT_W'(1);
                if (last) active <= 1'b0;
            end
        end
    end

    a_r9_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        active |-> (ocnt < out_ppl));
    a_r8_rcv_bound: assert property (@(posedge clk) disable iff (!rst_n)
        active |-> (rcv <= in_ppl));
    a_r4_valid_held: assert property (@(posedge clk) disable iff (!rst_n)
        (out_vld && !out_rdy) |=> out_vld);
    a_r7_no_take_when_held: assert property (@(posedge clk) disable iff (!rst_n)
        (out_vld && !out_rdy) |-> !in_rdy);
    a_r10_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (in_vld && in_rdy && in_hs) |=> (acc == '0 && rcv == CNT_W'(1)));
endmodule

// File: rtl/hscale_mac.sv
// Per-channel two-tap blend with rounding; one generated slice per colour channel.
// Assumes the left weight is 2^COEF_W minus the right weight.
module hscale_mac
    import hscale_pkg::*;
#(
    parameter int CH_W   = CH_W_D,
    parameter int NCH    = NCH_D,
    parameter int COEF_W = COEF_W_D
) (
    input  logic [CH_W*NCH-1:0] tap_l,
    input  logic [CH_W*NCH-1:0] tap_r,
    input  logic [COEF_W-1:0]   w,
    output logic [CH_W*NCH-1:0] y
);
    localparam int SW = CH_W + COEF_W + 1;

    logic [COEF_W:0] wl;
    assign wl = (COEF_W+1)'(1 << COEF_W) - (COEF_W+1)'(w);

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        logic [SW-1:0] sum;
        // Weighted sum plus half an LSB, then drop the weight fraction.
        always_comb begin
            sum = SW'(tap_l[c*CH_W +: CH_W]) * SW'(wl)
                + SW'(tap_r[c*CH_W +: CH_W]) * SW'(w)
                + SW'(1 << (COEF_W - 1));
            y[c*CH_W +: CH_W] = sum[COEF_W +: CH_W];
        end
    end
endmodule

// File: rtl/hscale_resampler.sv
// Top of the horizontal resampler: controller, weight bank and per-channel blend.
// Assumes runtime sizes are held steady during a line and in_ppl is at least 1.
module hscale_resampler
    import hscale_pkg::*;
#(
    parameter int CH_W   = CH_W_D,
    parameter int NCH    = NCH_D,
    parameter int CNT_W  = CNT_W_D,
    parameter int ACC_W  = ACC_W_D,
    parameter int FRAC_W = FRAC_W_D,
    parameter int PH_W   = PH_W_D,
    parameter int COEF_W = COEF_W_D
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [ACC_W-1:0]     pitch,
    input  logic [CNT_W-1:0]     in_ppl,
    input  logic [CNT_W-1:0]     out_ppl,
    input  logic                 coef_we,
    input  logic [PH_W-1:0]      coef_idx,
    input  logic [COEF_W-1:0]    coef_w,
    input  logic [CH_W*NCH-1:0]  in_pix,
    input  logic                 in_vld,
    input  logic                 in_hs,
    input  logic                 in_vs,
    output logic                 in_rdy,
    output logic [CH_W*NCH-1:0]  out_pix,
    output logic                 out_vld,
    output logic                 out_hs,
    output logic                 out_vs,
    input  logic                 out_rdy
);
    localparam int PIX_W = CH_W * NCH;

    logic [PIX_W-1:0]  tap_l, tap_r;
    logic [PH_W-1:0]   phase;
    logic [COEF_W-1:0] w;

    hscale_ctrl #(.PIX_W(PIX_W), .CNT_W(CNT_W), .ACC_W(ACC_W), .FRAC_W(FRAC_W), .PH_W(PH_W)) ctrl_i (
        .clk(clk), .rst_n(rst_n), .pitch(pitch), .in_ppl(in_ppl), .out_ppl(out_ppl),
        .in_pix(in_pix), .in_vld(in_vld), .in_hs(in_hs), .in_vs(in_vs), .in_rdy(in_rdy),
        .out_rdy(out_rdy), .out_vld(out_vld), .out_hs(out_hs), .out_vs(out_vs),
        .tap_l(tap_l), .tap_r(tap_r), .phase(phase)
    );

    hscale_coef_bank #(.PH_W(PH_W), .COEF_W(COEF_W)) bank_i (
        .clk(clk), .rst_n(rst_n), .we(coef_we), .wr_idx(coef_idx), .wr_w(coef_w),
        .rd_idx(phase), .rd_w(w)
    );

    hscale_mac #(.CH_W(CH_W), .NCH(NCH), .COEF_W(COEF_W)) mac_i (
        .tap_l(tap_l), .tap_r(tap_r), .w(w), .y(out_pix)
    );

    a_r2_equal_taps: assert property (@(posedge clk) disable iff (!rst_n)
        (out_vld && tap_l == tap_r) |-> (out_pix == tap_l));
    a_r4_data_held: assert property (@(posedge clk) disable iff (!rst_n)
        (out_vld && !out_rdy && !coef_we) |=> $stable(out_pix));
    a_r6_vs_needs_hs: assert property (@(posedge clk) disable iff (!rst_n)
        out_vs |-> (out_hs && out_vld));
endmodule

// File: tb/hscale_resampler_tb.sv
// Bench: directed corner lines plus seeded random lines, every output checked
// against a model computed here from the requirements.
module hscale_resampler_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [23:0] pitch = '0;
    logic [15:0] in_ppl = 16'd1, out_ppl = 16'd1;
    logic        coef_we = 1'b0;
    logic [3:0]  coef_idx = '0;
    logic [7:0]  coef_w = '0;
    logic [23:0] in_pix = '0;
    logic        in_vld = 1'b0, in_hs = 1'b0, in_vs = 1'b0;
    logic        in_rdy;
    logic [23:0] out_pix;
    logic        out_vld, out_hs, out_vs;
    logic        out_rdy = 1'b0;

    int          n_chk = 0, n_bad = 0;
    int          cyc = 0;
    logic [23:0] px [0:255];
    logic [7:0]  cm [0:15];
    int          first_c, last_c, stall_seen;
    bit          done = 1'b0;

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    hscale_resampler dut_i (
        .clk(clk), .rst_n(rst_n), .pitch(pitch), .in_ppl(in_ppl), .out_ppl(out_ppl),
        .coef_we(coef_we), .coef_idx(coef_idx), .coef_w(coef_w),
        .in_pix(in_pix), .in_vld(in_vld), .in_hs(in_hs), .in_vs(in_vs), .in_rdy(in_rdy),
        .out_pix(out_pix), .out_vld(out_vld), .out_hs(out_hs), .out_vs(out_vs),
        .out_rdy(out_rdy)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    // Model of output k of the current line (R1, R2, R8).
    function automatic logic [23:0] exp_pix(int n, int k, logic [23:0] p);
        logic [23:0] pos;
        int li, ri, w, s;
        logic [23:0] r;
        pos = 24'(k * p);
        li  = int'(pos[23:12]);
        ri  = li + 1;
        if (li > n - 1) li = n - 1;
        if (ri > n - 1) ri = n - 1;
        w = int'(cm[pos[11:8]]);
        for (int c = 0; c < 3; c++) begin
            s = int'(px[li][c*8 +: 8]) * (256 - w) + int'(px[ri][c*8 +: 8]) * w + 128;
            r[c*8 +: 8] = 8'(s >> 8);
        end
        return r;
    endfunction

    task automatic wr_coef(input int idx, input int w);
        @(negedge clk);
        coef_we = 1'b1; coef_idx = 4'(idx); coef_w = 8'(w);
        @(negedge clk);
        coef_we = 1'b0;
        cm[idx] = 8'(w);
    endtask

    // Stream one line and check every output pixel and marker.
    task automatic run_line(input int n, input int m, input logic [23:0] p, input bit ff,
                            input int vprob, input int rprob);
        int sent, got, guard;
        bit held;
        logic [23:0] held_pix;
        pitch = p; in_ppl = 16'(n); out_ppl = 16'(m);
        for (int i = 0; i < n; i++) px[i] = $urandom;
        sent = 0; got = 0; guard = 0; held = 0; held_pix = '0;
        first_c = -1; last_c = -1; stall_seen = 0;
        while ((got < m || sent < n) && guard < 5000) begin
            @(negedge clk);
            guard++;
            in_vld = (sent < n) && (($urandom % 100) < vprob);
            if (in_vld) begin
                in_pix = px[sent]; in_hs = (sent == 0); in_vs = (sent == 0) && ff;
            end else begin
                in_pix = $urandom; in_hs = 1'($urandom); in_vs = 1'($urandom); // R5 noise
            end
            out_rdy = (($urandom % 100) < rprob);
            #1;
            if (held) begin
                check(out_vld && out_pix == held_pix, "R4 held output", out_pix, held_pix);
            end
            if (in_vld && !in_rdy && sent > 0) stall_seen++;
            if (in_vld && in_rdy) sent++;
            if (out_vld && out_rdy) begin
                if (got >= m) begin
                    check(1'b0, "R9 extra output", got, m);
                end else begin
                    check(out_pix == exp_pix(n, got, p), "R1 R2 R8 pixel value", out_pix, exp_pix(n, got, p));
                    check(out_hs == (got == 0), "R6 out_hs", out_hs, (got == 0));
                    check(out_vs == (got == 0 && ff), "R6 out_vs", out_vs, (got == 0 && ff));
                end
                if (first_c < 0) first_c = cyc;
                last_c = cyc;
                got++;
            end
            held = out_vld && !out_rdy;
            held_pix = out_pix;
        end
        check(guard < 5000, "R9 line completion", got, m);
        @(negedge clk);
        in_vld = 1'b0; in_hs = 1'b0; in_vs = 1'b0; out_rdy = 1'b1;
    endtask

    // Watchdog: an expired run counts as a failure and still reports.
    initial begin
        wait (cyc > 150000);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog act=%0d exp=done", cyc);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        for (int p = 0; p < 16; p++) cm[p] = 8'(p * 16);
        repeat (3) @(negedge clk);
        #1;
        check(out_vld == 1'b0, "R11 reset out_vld", out_vld, 0);
        check(in_rdy == 1'b1, "R11 reset in_rdy", in_rdy, 1);
        @(negedge clk); rst_n = 1'b1;

        // R7 full-rate upscale 10 -> 16, pitch 2560; default weights exercise R3.
        run_line(10, 16, 24'd2560, 1'b1, 100, 100);
        check(last_c - first_c == 15, "R7 consecutive outputs", last_c - first_c, 15);
        check(stall_seen > 0, "R7 input ready dropped", stall_seen, 1);

        // Downscale with gaps on both sides; R10 start from zero after a prior line.
        run_line(16, 10, 24'd6553, 1'b0, 60, 50);

        // R8 clamp: position runs past the last input pixel.
        run_line(5, 8, 24'd4096, 1'b0, 80, 80);
        // R8 single-pixel line.
        run_line(1, 4, 24'd1024, 1'b1, 90, 70);

        // R9 / R5 idle behaviour after a finished line.
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            in_vld = 1'b0; in_hs = 1'b1; in_vs = 1'b1; in_pix = $urandom;
            #1;
            check(out_vld == 1'b0, "R5 invalid marker ignored", out_vld, 0);
        end
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            in_vld = 1'b1; in_hs = 1'b0; in_vs = 1'b0; in_pix = $urandom;
            #1;
            check(in_rdy == 1'b1, "R9 trailing pixel accepted", in_rdy, 1);
            check(out_vld == 1'b0, "R9 no output after count", out_vld, 0);
        end
        @(negedge clk); in_vld = 1'b0;

        // R3 programmed weights, including extremes.
        wr_coef(0, 0);
        wr_coef(5, 255);
        for (int p = 1; p < 16; p++) if (p != 5) wr_coef(p, $urandom % 256);
        run_line(12, 20, 24'd2457, 1'b1, 85, 85);
        run_line(20, 7, 24'd11702, 1'b0, 70, 60);

        // Random lines.
        for (int t = 0; t < 30; t++) begin
            int n, m;
            n = 2 + int'($urandom % 40);
            m = 1 + int'($urandom % 40);
            run_line(n, m, 24'((n * 4096) / m), (t % 4) == 0, 50 + int'($urandom % 50), 50 + int'($urandom % 50));
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule